// File: doc/BRIEF.md
# Accessory Detection Switch Controller

This block sits behind the ID-pin converter and VBUS comparator of a micro-USB port. It reads a 5-bit resistor code from the ID pin, the VBUS-present flag and the outcome of an external charger classification. From these it decides which accessory is plugged in, raises one device-flag bit for it, and routes the connector's D+ and D− lines to the USB host path, the UART path, or nowhere. It also drives a factory-test JIG output and a BOOT level.

A new plug is not acted on at once. The controller first waits a programmable wake-up time, during which the code must stay steady. It then latches the device type and reports an attach event. A programmable switching wait follows before the switches close. An optional host handshake can hold the switches open past that point.

Any change of code or VBUS after the latch is treated as a detach, and the controller then detects the new plug from the start. Register bits can take over the switches directly in manual mode. An open-all bit overrides every other source.

Top module: `acc_switch_ctrl`

## Requirements
- R1: After reset, dp_sel and dm_sel are 00 (open), jig_on and boot_hi are 0, dev_flags is all zeros, id_rpt is 11111, and neither event output is high.
- R2: While id_code is 11111 and vbus_ok is 0, the controller stays idle: no attach event occurs and, in automatic mode, every switch stays open.
- R3: Code decoding in automatic mode routes both lines the same way. Path encoding is 00 open, 01 USB, 10 UART. The codes are: 00000 → USB; 10100 and 10110 → UART; 11000 → USB with JIG on, BOOT low; 11001 → USB with JIG on, BOOT high; 11100 → UART with JIG on, BOOT low; 11101 → UART with JIG on, BOOT high. Every other code leaves the switches open.
- R4: With code 11111 and vbus_ok high, chg_type selects the result: 0 (standard port) → USB; 1 (charging port) → USB; 2 (dedicated charger) → open; 3 (unclassified) → open.
- R5: Exactly one dev_flags bit is set while an accessory is latched. The bit positions are: 0 OTG (00000), 1 standard port, 2 charging port, 3 dedicated charger, 4 phone-powered device (10100), 5 UART cable (10110), 6 code 11000, 7 code 11001, 8 code 11100, 9 code 11101, 10 any other attached code or unclassified charger.
- R6: The wake-up time set by wake_sel s is 50·(s+1) ms for s ≤ 3, 100·(s−1) ms for 4 ≤ s ≤ 11, and 1000 ms above 11.
- R7: The switching wait set by swwait_sel s is 10+20·s ms for s ≤ 10, and 210 ms above 10. One ms is CLK_PER_MS clocks. Measured in rising edges from the first edge that sees the plug, attach_evt is high after edge 2+P·W and the switches close after edge 3+P·(W+S), where P is CLK_PER_MS, W the wake-up time and S the switching wait.
- R8: While ctl_wait is 0, the switches do not close after the switching wait. They close one edge after ctl_wait goes high.
- R9: attach_evt is a one-cycle pulse. In that cycle, id_rpt shows the latched code and dev_flags shows the decoded type.
- R10: A change of id_code or vbus_ok after the latch produces a one-cycle detach_evt in the next cycle, together with open switches, dev_flags cleared and id_rpt at 11111. A new code present at that point is detected again, and its switches close one edge later than in R7.
- R11: With ctl_auto at 0, each of man_dp and man_dm maps 001 to USB, 011 to UART and every other value to open. jig_on follows man_jig and boot_hi follows man_boot, with no clock delay.
- R12: With ctl_sw_en at 0, both lines are open and jig_on and boot_hi are 0 in every mode, while dev_flags keeps its value.
- R13: A code change during the wake-up time restarts the wake-up timer with the new code, and no detach event is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_code | input | 5 | ID-pin resistor code from the converter |
| vbus_ok | input | 1 | VBUS present |
| chg_type | input | 2 | Charger classification result |
| ctl_auto | input | 1 | 1 automatic routing, 0 manual routing |
| ctl_sw_en | input | 1 | 0 forces every switch open |
| ctl_wait | input | 1 | 1 closes on timer expiry, 0 holds for the host |
| wake_sel | input | 4 | Wake-up time setting |
| swwait_sel | input | 4 | Switching wait setting |
| man_dp | input | 3 | Manual D+ routing field |
| man_dm | input | 3 | Manual D− routing field |
| man_jig | input | 1 | Manual JIG drive |
| man_boot | input | 1 | Manual BOOT level |
| dp_sel | output | 2 | D+ path: 00 open, 01 USB, 10 UART |
| dm_sel | output | 2 | D− path: 00 open, 01 USB, 10 UART |
| jig_on | output | 1 | JIG driven active |
| boot_hi | output | 1 | BOOT level |
| dev_flags | output | 11 | One-hot device type |
| id_rpt | output | 5 | Latched ID code, 11111 when none |
| attach_evt | output | 1 | Attach pulse |
| detach_evt | output | 1 | Detach pulse |

## Verification
The assertions check on every cycle the following properties. The device flags are never more than one-hot. JIG is never driven on an open path. The millisecond counter only counts down and rests at zero. The switches never close before the switching timer expires or while the host hold is active. The attach pulse lasts exactly one cycle, and a detach always arrives with cleared flags and report. Only the bench's scenarios can show the rest: the exact decode of every code, the arithmetic of both duration settings down to the cycle, the restart of the wake-up time on a code change, the re-detection after an in-place swap, and the precedence of the open-all bit over manual and automatic routing.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int CODE_W = 5;
    localparam int FLAG_W = 11;
    localparam int MS_W   = 10;

    localparam logic [CODE_W-1:0] CODE_NONE  = 5'b11111;
    localparam logic [CODE_W-1:0] CODE_OTG   = 5'b00000;
    localparam logic [CODE_W-1:0] CODE_PPD   = 5'b10100;
    localparam logic [CODE_W-1:0] CODE_UARTC = 5'b10110;
    localparam logic [CODE_W-1:0] CODE_FU_B0 = 5'b11000;
    localparam logic [CODE_W-1:0] CODE_FU_B1 = 5'b11001;
    localparam logic [CODE_W-1:0] CODE_FA_B0 = 5'b11100;
    localparam logic [CODE_W-1:0] CODE_FA_B1 = 5'b11101;

    localparam int F_OTG   = 0;
    localparam int F_SDP   = 1;
    localparam int F_CDP   = 2;
    localparam int F_DCP   = 3;
    localparam int F_PPD   = 4;
    localparam int F_UARTC = 5;
    localparam int F_FU_B0 = 6;
    localparam int F_FU_B1 = 7;
    localparam int F_FA_B0 = 8;
    localparam int F_FA_B1 = 9;
    localparam int F_OTHER = 10;

    typedef enum logic [1:0] {PATH_OPEN = 2'b00, PATH_USB = 2'b01, PATH_UART = 2'b10} path_e;
    typedef enum logic [1:0] {CHG_SDP = 2'd0, CHG_CDP = 2'd1, CHG_DCP = 2'd2, CHG_NONE = 2'd3} chg_e;
    typedef enum logic [1:0] {ST_IDLE, ST_WAKE, ST_SETTLE, ST_LINKED} st_e;

    typedef struct packed {
        path_e             path;
        logic              jig;
        logic              boot;
        logic [FLAG_W-1:0] flags;
    } route_t;

    function automatic logic [MS_W-1:0] wake_ms(input logic [3:0] s);
        int v;
        if (int'(s) <= 3)       v = 50 * (int'(s) + 1);
        else if (int'(s) <= 11) v = 100 * (int'(s) - 1);
        else                    v = 1000;
        return MS_W'(v);
    endfunction

    function automatic logic [MS_W-1:0] wait_ms(input logic [3:0] s);
        int v;
        if (int'(s) <= 10) v = 10 + 20 * int'(s);
        else               v = 210;
        return MS_W'(v);
    endfunction
endpackage

// File: rtl/acc_id_decode.sv
module acc_id_decode
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  logic              vbus,
    input  logic [1:0]        chg,
    output route_t            rt
);
    always_comb begin
        rt = '0;
        case (code)
            CODE_OTG:   begin rt.path = PATH_USB;  rt.flags[F_OTG]   = 1'b1; end
            CODE_PPD:   begin rt.path = PATH_UART; rt.flags[F_PPD]   = 1'b1; end
            CODE_UARTC: begin rt.path = PATH_UART; rt.flags[F_UARTC] = 1'b1; end
            CODE_FU_B0: begin rt.path = PATH_USB;  rt.jig = 1'b1; rt.flags[F_FU_B0] = 1'b1; end
            CODE_FU_B1: begin rt.path = PATH_USB;  rt.jig = 1'b1; rt.boot = 1'b1; rt.flags[F_FU_B1] = 1'b1; end
            CODE_FA_B0: begin rt.path = PATH_UART; rt.jig = 1'b1; rt.flags[F_FA_B0] = 1'b1; end
            CODE_FA_B1: begin rt.path = PATH_UART; rt.jig = 1'b1; rt.boot = 1'b1; rt.flags[F_FA_B1] = 1'b1; end
            CODE_NONE: begin
                if (vbus) begin
                    case (chg_e'(chg))
                        CHG_SDP: begin rt.path = PATH_USB; rt.flags[F_SDP] = 1'b1; end
                        CHG_CDP: begin rt.path = PATH_USB; rt.flags[F_CDP] = 1'b1; end
                        CHG_DCP: rt.flags[F_DCP] = 1'b1;
                        default: rt.flags[F_OTHER] = 1'b1;
                    endcase
                end
            end
            default: rt.flags[F_OTHER] = 1'b1;
        endcase
    end

    p_flags_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(rt.flags));
    p_jig_needs_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rt.jig |-> (rt.path != PATH_OPEN));
endmodule

// File: rtl/acc_ms_timer.sv
module acc_ms_timer
    import acc_pkg::*;
#(
    parameter int CLK_PER_MS = 100000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [MS_W-1:0] load_ms,
    output logic            done
);
    localparam int PW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_MS - 1);

    typedef struct packed {
        logic [PW-1:0]   pre;
        logic [MS_W-1:0] ms;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.pre = '0;
            d.ms  = load_ms;
        end else if (q.pre == PRE_LAST) begin
            d.pre = '0;
            if (q.ms != '0) d.ms = q.ms - 1'b1;
        end else begin
            d.pre = q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = (q.ms == '0);

    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && q.ms != '0) |=> (q.ms <= $past(q.ms)));
    p_rest_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && q.ms == '0) |=> (q.ms == '0));
endmodule

// File: rtl/acc_switch_ctrl.sv
module acc_switch_ctrl
    import acc_pkg::*;
#(
    parameter int CLK_PER_MS = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        id_code,
    input  logic              vbus_ok,
    input  logic [1:0]        chg_type,
    input  logic              ctl_auto,
    input  logic              ctl_sw_en,
    input  logic              ctl_wait,
    input  logic [3:0]        wake_sel,
    input  logic [3:0]        swwait_sel,
    input  logic [2:0]        man_dp,
    input  logic [2:0]        man_dm,
    input  logic              man_jig,
    input  logic              man_boot,
    output logic [1:0]        dp_sel,
    output logic [1:0]        dm_sel,
    output logic              jig_on,
    output logic              boot_hi,
    output logic [FLAG_W-1:0] dev_flags,
    output logic [4:0]        id_rpt,
    output logic              attach_evt,
    output logic              detach_evt
);
    typedef struct packed {
        st_e               st;
        logic [CODE_W-1:0] code;
        logic              vbus;
        route_t            rt;
        logic [CODE_W-1:0] rpt;
        logic              att;
        logic              det;
    } ctl_t;

    ctl_t   q, d;
    route_t dec_rt;
    logic   tload, tdone;
    logic [MS_W-1:0] tms;
    logic   present, changed;

    acc_id_decode u_dec (
        .clk(clk), .rst_n(rst_n), .code(q.code), .vbus(q.vbus), .chg(chg_type), .rt(dec_rt)
    );

    acc_ms_timer #(.CLK_PER_MS(CLK_PER_MS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tload), .load_ms(tms), .done(tdone)
    );

    function automatic path_e man_map(input logic [2:0] f);
        case (f)
            3'b001:  return PATH_USB;
            3'b011:  return PATH_UART;
            default: return PATH_OPEN;
        endcase
    endfunction

    assign present = (id_code != CODE_NONE) || vbus_ok;
    assign changed = (id_code != q.code) || (vbus_ok != q.vbus);

    always_comb begin
        d     = q;
        d.att = 1'b0;
        d.det = 1'b0;
        tload = 1'b0;
        tms   = '0;
        case (q.st)
            ST_IDLE: begin
                if (present) begin
                    d.st   = ST_WAKE;
                    d.code = id_code;
                    d.vbus = vbus_ok;
                    tload  = 1'b1;
                    tms    = wake_ms(wake_sel);
                end
            end
            ST_WAKE: begin
                if (changed) begin
                    d.code = id_code;
                    d.vbus = vbus_ok;
                    if (!present) begin
                        d.st = ST_IDLE;
                    end else begin
                        tload = 1'b1;
                        tms   = wake_ms(wake_sel);
                    end
                end else if (tdone) begin
                    d.st  = ST_SETTLE;
                    d.rt  = dec_rt;
                    d.rpt = q.code;
                    d.att = 1'b1;
                    tload = 1'b1;
                    tms   = wait_ms(swwait_sel);
                end
            end
            ST_SETTLE, ST_LINKED: begin
                if (changed) begin
                    d.st   = ST_IDLE;
                    d.code = CODE_NONE;
                    d.vbus = 1'b0;
                    d.rt   = '0;
                    d.rpt  = CODE_NONE;
                    d.det  = 1'b1;
                end else if (q.st == ST_SETTLE && tdone && ctl_wait) begin
                    d.st = ST_LINKED;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.code <= CODE_NONE;
            q.rpt  <= CODE_NONE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        dp_sel  = PATH_OPEN;
        dm_sel  = PATH_OPEN;
        jig_on  = 1'b0;
        boot_hi = 1'b0;
        if (ctl_sw_en) begin
            if (!ctl_auto) begin
                dp_sel  = man_map(man_dp);
                dm_sel  = man_map(man_dm);
                jig_on  = man_jig;
                boot_hi = man_boot;
            end else if (q.st == ST_LINKED) begin
                dp_sel  = q.rt.path;
                dm_sel  = q.rt.path;
                jig_on  = q.rt.jig;
                boot_hi = q.rt.boot;
            end
        end
    end

    assign dev_flags  = q.rt.flags;
    assign id_rpt     = q.rpt;
    assign attach_evt = q.att;
    assign detach_evt = q.det;

    p_no_close_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SETTLE && !tdone) |=> (q.st != ST_LINKED));
    p_host_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SETTLE && !ctl_wait) |=> (q.st != ST_LINKED));
    p_attach_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.att |=> !q.att);
    p_detach_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.det |-> (q.rt.flags == '0 && q.rpt == CODE_NONE && q.st == ST_IDLE));
    p_wake_restart_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAKE) |=> !q.det);
endmodule

// File: tb/acc_switch_ctrl_tb_top.sv
module acc_switch_ctrl_tb_top;
    localparam int P = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] id_code = 5'b11111;
    logic vbus_ok = 1'b0;
    logic [1:0] chg_type = 2'd3;
    logic ctl_auto = 1'b1, ctl_sw_en = 1'b1, ctl_wait = 1'b1;
    logic [3:0] wake_sel = 4'd0, swwait_sel = 4'd0;
    logic [2:0] man_dp = 3'd0, man_dm = 3'd0;
    logic man_jig = 1'b0, man_boot = 1'b0;
    logic [1:0] dp_sel, dm_sel;
    logic jig_on, boot_hi;
    logic [10:0] dev_flags;
    logic [4:0] id_rpt;
    logic attach_evt, detach_evt;

    int n_chk = 0, n_fail = 0;
    int att_at, det_at, close_at;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    acc_switch_ctrl #(.CLK_PER_MS(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .id_code(id_code), .vbus_ok(vbus_ok), .chg_type(chg_type),
        .ctl_auto(ctl_auto), .ctl_sw_en(ctl_sw_en), .ctl_wait(ctl_wait),
        .wake_sel(wake_sel), .swwait_sel(swwait_sel), .man_dp(man_dp), .man_dm(man_dm),
        .man_jig(man_jig), .man_boot(man_boot), .dp_sel(dp_sel), .dm_sel(dm_sel),
        .jig_on(jig_on), .boot_hi(boot_hi), .dev_flags(dev_flags), .id_rpt(id_rpt),
        .attach_evt(attach_evt), .detach_evt(detach_evt)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int wake_exp(input int s);
        if (s < 4) return 50 + 50 * s;
        if (s < 12) return 300 + 100 * (s - 4);
        return 1000;
    endfunction

    function automatic int wait_exp(input int s);
        return (s > 10) ? 210 : 10 + 20 * s;
    endfunction

    function automatic int man_exp(input int f);
        if (f == 1) return 1;
        if (f == 3) return 2;
        return 0;
    endfunction

    task automatic exp_of(input int c, input int v, input int ch,
                          output int path, output int jg, output int bt, output int fb);
        path = 0; jg = 0; bt = 0; fb = 10;
        if (c == 0)       begin path = 1; fb = 0; end
        else if (c == 20) begin path = 2; fb = 4; end
        else if (c == 22) begin path = 2; fb = 5; end
        else if (c >= 24 && c <= 25) begin path = 1; jg = 1; bt = c - 24; fb = c - 18; end
        else if (c >= 28 && c <= 29) begin path = 2; jg = 1; bt = c - 28; fb = c - 20; end
        else if (c == 31 && v == 1) begin
            if (ch == 0) begin path = 1; fb = 1; end
            else if (ch == 1) begin path = 1; fb = 2; end
            else if (ch == 2) fb = 3;
        end
    endtask

    task automatic apply(input int c, input int v, input int ch);
        @(negedge clk);
        id_code = 5'(c); vbus_ok = 1'(v); chg_type = 2'(ch);
    endtask

    task automatic observe(input int limit);
        att_at = 0; det_at = 0; close_at = 0;
        for (int n = 1; n <= limit; n++) begin
            @(negedge clk);
            if (attach_evt && att_at == 0) att_at = n;
            if (detach_evt && det_at == 0) det_at = n;
            if ((dp_sel != 0 || jig_on) && close_at == 0) close_at = n;
        end
    endtask

    task automatic unplug();
        apply(31, 0, 3);
        @(negedge clk);
        check("R10 detach pulse", int'(detach_evt), 1);
        check("R10 flags cleared", int'(dev_flags), 0);
        check("R10 report idle", int'(id_rpt), 31);
        check("R10 switches open", int'(dp_sel), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int path, jg, bt, fb, base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 dp", int'(dp_sel), 0);
        check("R1 dm", int'(dm_sel), 0);
        check("R1 jig", int'(jig_on), 0);
        check("R1 boot", int'(boot_hi), 0);
        check("R1 flags", int'(dev_flags), 0);
        check("R1 report", int'(id_rpt), 31);
        check("R1 events", int'(attach_evt) + int'(detach_evt), 0);

        // R2 idle with nothing attached
        observe(60);
        check("R2 no attach", att_at, 0);
        check("R2 open", close_at, 0);

        // R3 R4 R5 R9 sweep over all codes (and VBUS charger types)
        base = P * (50 + 10);
        for (int k = 0; k < 35; k++) begin
            int c, v, ch;
            c  = (k < 31) ? k : 31;
            v  = (k < 31) ? 0 : 1;
            ch = (k < 31) ? 3 : k - 31;
            exp_of(c, v, ch, path, jg, bt, fb);
            apply(c, v, ch);
            att_at = 0; close_at = 0;
            for (int n = 1; n <= base + 6; n++) begin
                @(negedge clk);
                if (attach_evt && att_at == 0) begin
                    att_at = n;
                    check("R9 report on attach", int'(id_rpt), c);
                    check("R5 flag on attach", int'(dev_flags), 1 << fb);
                end
                if ((dp_sel != 0 || jig_on) && close_at == 0) close_at = n;
            end
            check("R9 attach time", att_at, 2 + P * 50);
            check("R3 dp path", int'(dp_sel), path);
            check("R3 dm path", int'(dm_sel), path);
            check("R3 jig", int'(jig_on), jg);
            check("R3 boot", int'(boot_hi), bt);
            check("R4 R5 flags", int'(dev_flags), 1 << fb);
            if (path != 0) check("R7 close time", close_at, base + 3);
            unplug();
        end

        // R6 wake-up setting sweep
        for (int s = 0; s < 16; s++) begin
            wake_sel = 4'(s);
            apply(24, 0, 3);
            observe(3 + P * (wake_exp(s) + 10) + 2);
            check("R6 wake time", close_at, 3 + P * (wake_exp(s) + 10));
            unplug();
        end
        wake_sel = 4'd0;

        // R7 switching-wait setting sweep
        for (int s = 0; s < 16; s++) begin
            swwait_sel = 4'(s);
            apply(28, 0, 3);
            observe(3 + P * (50 + wait_exp(s)) + 2);
            check("R7 wait time", close_at, 3 + P * (50 + wait_exp(s)));
            unplug();
        end
        swwait_sel = 4'd0;

        // R8 host hold
        ctl_wait = 1'b0;
        apply(22, 0, 3);
        observe(base + 40);
        check("R8 held open", close_at, 0);
        check("R8 still open", int'(dp_sel), 0);
        ctl_wait = 1'b1;
        @(negedge clk);
        check("R8 close on release", int'(dp_sel), 2);
        unplug();

        // R10 swap while linked
        apply(24, 0, 3);
        observe(base + 5);
        apply(22, 0, 3);
        observe(base + 8);
        check("R10 detach next cycle", det_at, 1);
        check("R10 reclose time", close_at, base + 4);
        check("R10 new path", int'(dp_sel), 2);
        unplug();

        // R13 code change during wake-up
        apply(24, 0, 3);
        repeat (40) @(negedge clk);
        id_code = 5'd25;
        observe(base + 6);
        check("R13 no detach", det_at, 0);
        check("R13 restart time", close_at, base + 3);
        check("R13 new boot", int'(boot_hi), 1);

        // R12 open-all while linked in automatic mode
        ctl_sw_en = 1'b0;
        #2;
        check("R12 dp forced", int'(dp_sel), 0);
        check("R12 jig forced", int'(jig_on), 0);
        check("R12 boot forced", int'(boot_hi), 0);
        check("R12 flags kept", int'(dev_flags), 1 << 7);
        ctl_sw_en = 1'b1;
        #2;
        check("R12 restore", int'(dp_sel), 1);
        unplug();

        // R11 manual mode sweep
        ctl_auto = 1'b0;
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                for (int j = 0; j < 4; j++) begin
                    man_dp = 3'(a); man_dm = 3'(b);
                    man_jig = j[0]; man_boot = j[1];
                    #1;
                    check("R11 dp", int'(dp_sel), man_exp(a));
                    check("R11 dm", int'(dm_sel), man_exp(b));
                    check("R11 jig", int'(jig_on), j % 2);
                    check("R11 boot", int'(boot_hi), j / 2);
                end
        // R12 open-all in manual mode
        man_dp = 3'd1; man_dm = 3'd3; man_jig = 1'b1; man_boot = 1'b1;
        ctl_sw_en = 1'b0;
        #1;
        check("R12 manual dp", int'(dp_sel), 0);
        check("R12 manual dm", int'(dm_sel), 0);
        check("R12 manual jig", int'(jig_on), 0);
        check("R12 manual boot", int'(boot_hi), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule